// File: doc/BRIEF.md
# Clock Control Register Bank with Enable-Strobe Divider Chain

This block holds a window of 28 32-bit control words, reached over a simple single-cycle read/write bus, and turns a reference strobe or a main PLL strobe into single-cycle enable pulses for a CPU domain, a system-bus (AHB) domain and a peripheral (IPG) domain. The path is: source select (PLL or bypass to the reference), an optional pulse-swallow step that keeps three of every four strobes, a CPU divider of (1 + field), an AHB divider of (1 + field), and a fixed halving for the peripheral enable. A second PLL strobe is passed through as a USB enable unless a disable bit in the control word is set.

All strobe inputs are expected to be single-cycle pulses in the system clock domain; the enables are combinational functions of the current strobe and the divider state, so each enable pulse lines up with the source strobe that produces it. Control word fields: bits 31:30 CPU divide, bits 29:28 AHB divide, bit 23 USB PLL disable, bit 22 main PLL bypass, bit 14 three-quarter step. The control word sits at offset 0x08.

Top module: `clk_ctl_unit`

## Requirements
- R1: After synchronous reset, reads return 0x800b2c01 at offset 0x00, 0x84042800 at 0x04, 0xd0030000 at 0x08, 0x01010101 at 0x18, 0x1c, 0x20 and 0x24, and zero at every other offset below 0x70.
- R2: An aligned write at an offset below 0x70 stores the full word in register index offset>>2; a read there returns it on the bus one clock after the read request, with the error flag low.
- R3: An access at offset 0x70 or above, or with offset bits 1:0 not zero, raises the error flag for one cycle one clock after the request; such a read returns zero and such a write changes no register.
- R4: With bit 22 of the control word set the chain source and `main_en` follow `ref_stb`; with it clear they follow `main_pll_stb`.
- R5: With bit 14 set, of every four source strobes after the last control-word write the fourth is dropped before the CPU divider.
- R6: The CPU enable pulses once per (1 + bits 31:30) strobes leaving the pulse-swallow step.
- R7: The AHB enable pulses once per (1 + bits 29:28) CPU enable pulses.
- R8: The peripheral enable pulses on every second AHB enable pulse, never on two consecutive cycles.
- R9: With bit 23 set `usb_en` stays low; with it clear `usb_en` follows `usb_pll_stb`.
- R10: Any write to the control word restarts all divider and swallow counters, so the first CPU enable after it needs a full (1 + divide) count of strobes.
- R11: Every enable output is low in any cycle in which its source strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_addr | input | AW | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_err | output | 1 | One-cycle error pulse for a bad access |
| ref_stb | input | 1 | Reference clock strobe |
| main_pll_stb | input | 1 | Main PLL output strobe |
| usb_pll_stb | input | 1 | USB PLL output strobe |
| main_en | output | 1 | Selected main source enable |
| usb_en | output | 1 | USB PLL enable |
| cpu_en | output | 1 | CPU domain enable |
| ahb_en | output | 1 | AHB domain enable |
| ipg_en | output | 1 | Peripheral domain enable |

## Verification
The bench targets a stale divider count after a control-word write, which a design without the restart would show as an early CPU pulse after a partial count. It drives both main sources at once with independent patterns, so a bypass select that is inverted or ignored shows up as a wrong `main_en` count. Misaligned and out-of-window writes are followed by read-back of the neighbouring word, catching a design that decodes only the upper offset bits. Random divide fields including zero and the largest value, with the three-quarter step on and off, expose off-by-one dividers and a swallow step that drops the wrong strobe of each four.

// File: rtl/clk_ctl_unit.sv
module clk_ctl_unit #(
  parameter int NREG = 28,
  parameter int AW   = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          bus_err,
  input  logic          ref_stb,
  input  logic          main_pll_stb,
  input  logic          usb_pll_stb,
  output logic          main_en,
  output logic          usb_en,
  output logic          cpu_en,
  output logic          ahb_en,
  output logic          ipg_en
);
  localparam int LIMIT   = NREG * 4;
  localparam int IW      = $clog2(NREG);
  localparam int CTL_IDX = 2;

  function automatic logic [31:0] init_val(input int i);
    case (i)
      0:             return 32'h800b2c01;
      1:             return 32'h84042800;
      2:             return 32'hd0030000;
      6, 7, 8, 9:    return 32'h01010101;
      default:       return 32'h0;
    endcase
  endfunction

  logic [31:0]   regs [NREG];
  logic [IW-1:0] idx;
  logic          hit;
  logic          ctl_wr;

  assign idx    = bus_addr[IW+1:2];
  assign hit    = (int'(bus_addr) < LIMIT) && (bus_addr[1:0] == 2'b00);
  assign ctl_wr = bus_wr && hit && (int'(idx) == CTL_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= init_val(i);
    end else if (bus_wr && hit) begin
      regs[idx] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_err <= (bus_rd || bus_wr) && !hit;
      if (bus_rd) bus_rdata <= hit ? regs[idx] : 32'h0;
    end
  end

  logic [31:0] ctl;
  logic [1:0]  cpu_div, ahb_div;
  logic        usb_off, bypass, three_q;

  assign ctl     = regs[CTL_IDX];
  assign cpu_div = ctl[31:30];
  assign ahb_div = ctl[29:28];
  assign usb_off = ctl[23];
  assign bypass  = ctl[22];
  assign three_q = ctl[14];

  logic [1:0] q_cnt, c_cnt, a_cnt;
  logic       i_ph;
  logic       q_stb;

  assign main_en = bypass ? ref_stb : main_pll_stb;
  assign usb_en  = usb_pll_stb && !usb_off;
  assign q_stb   = main_en && !(three_q && q_cnt == 2'd3);
  assign cpu_en  = q_stb && (c_cnt == cpu_div);
  assign ahb_en  = cpu_en && (a_cnt == ahb_div);
  assign ipg_en  = ahb_en && i_ph;

  always_ff @(posedge clk) begin
    if (rst || ctl_wr) begin
      q_cnt <= '0;
      c_cnt <= '0;
      a_cnt <= '0;
      i_ph  <= 1'b0;
    end else begin
      if (main_en && three_q) q_cnt <= q_cnt + 2'd1;
      if (q_stb)  c_cnt <= cpu_en ? 2'd0 : c_cnt + 2'd1;
      if (cpu_en) a_cnt <= ahb_en ? 2'd0 : a_cnt + 2'd1;
      if (ahb_en) i_ph  <= !i_ph;
    end
  end
endmodule

module clk_ctl_unit_chk #(
  parameter int NREG = 28,
  parameter int AW   = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_rdata,
  input logic          bus_err,
  input logic          ref_stb,
  input logic          main_pll_stb,
  input logic          main_en,
  input logic          usb_en,
  input logic          cpu_en,
  input logic          ahb_en,
  input logic          ipg_en,
  input logic [31:0]   ctl
);
  localparam int LIMIT = NREG * 4;

  assert_rd_oob_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && int'(bus_addr) >= LIMIT) |=> (bus_err && bus_rdata == 32'h0));
  assert_wr_oob_err_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && int'(bus_addr) >= LIMIT) |=> bus_err);
  assert_bypass_src_R4: assert property (@(posedge clk) disable iff (rst)
    (ctl[22] && !ref_stb) |-> !main_en);
  assert_pll_src_R4: assert property (@(posedge clk) disable iff (rst)
    (!ctl[22] && !main_pll_stb) |-> !main_en);
  assert_cpu_needs_src_R11: assert property (@(posedge clk) disable iff (rst)
    cpu_en |-> main_en);
  assert_ahb_needs_cpu_R7: assert property (@(posedge clk) disable iff (rst)
    ahb_en |-> cpu_en);
  assert_ipg_needs_ahb_R8: assert property (@(posedge clk) disable iff (rst)
    ipg_en |-> ahb_en);
  assert_ipg_single_R8: assert property (@(posedge clk) disable iff (rst)
    ipg_en |=> !ipg_en);
  assert_usb_gated_R9: assert property (@(posedge clk) disable iff (rst)
    ctl[23] |-> !usb_en);
endmodule

bind clk_ctl_unit clk_ctl_unit_chk #(.NREG(NREG), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .bus_err(bus_err), .ref_stb(ref_stb),
  .main_pll_stb(main_pll_stb), .main_en(main_en), .usb_en(usb_en),
  .cpu_en(cpu_en), .ahb_en(ahb_en), .ipg_en(ipg_en), .ctl(regs[2])
);

// File: tb/clk_ctl_unit_test.sv
`timescale 1ns/1ps
module clk_ctl_unit_test;
  logic        clk = 0, rst = 1;
  logic        bus_wr = 0, bus_rd = 0;
  logic [11:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        bus_err;
  logic        ref_stb = 0, main_pll_stb = 0, usb_pll_stb = 0;
  logic        main_en, usb_en, cpu_en, ahb_en, ipg_en;

  int n_run = 0, n_fail = 0;
  logic [31:0] shadow [28];

  always #2 clk = ~clk;

  clk_ctl_unit uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .ref_stb(ref_stb), .main_pll_stb(main_pll_stb), .usb_pll_stb(usb_pll_stb),
    .main_en(main_en), .usb_en(usb_en), .cpu_en(cpu_en), .ahb_en(ahb_en), .ipg_en(ipg_en)
  );

  function automatic logic [31:0] reset_word(input int i);
    if (i == 0) return 32'h800b2c01;
    if (i == 1) return 32'h84042800;
    if (i == 2) return 32'hd0030000;
    if (i >= 6 && i <= 9) return 32'h01010101;
    return 32'h0;
  endfunction

  function automatic int after_swallow(input int n, input bit tq);
    return tq ? n - n / 4 : n;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d, output logic e);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
    e = bus_err;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata; e = bus_err;
  endtask

  task automatic run_chain(input int n, input bit byp, output int sel, output int m,
                           output int c, output int a, output int p, output int us,
                           output int u, output int stray);
    sel = 0; m = 0; c = 0; a = 0; p = 0; us = 0; u = 0; stray = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      main_pll_stb = 1'($urandom % 2);
      ref_stb      = 1'($urandom % 2);
      usb_pll_stb  = 1'($urandom % 2);
      #1;
      if (byp ? ref_stb : main_pll_stb) sel++;
      else if (main_en || cpu_en || ahb_en || ipg_en) stray++;
      if (usb_pll_stb) us++;
      else if (usb_en) stray++;
      m += int'(main_en); c += int'(cpu_en); a += int'(ahb_en);
      p += int'(ipg_en); u += int'(usb_en);
    end
    @(negedge clk);
    main_pll_stb = 0; ref_stb = 0; usb_pll_stb = 0;
  endtask

  task automatic main_pulses(input int n, output int c);
    c = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      main_pll_stb = 1;
      #1 c += int'(cpu_en);
      @(negedge clk);
      main_pll_stb = 0;
    end
  endtask

  initial begin
    #800000;
    n_run++; n_fail++;
    $display("FAIL watchdog R1..: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic e;
    int sel, m, c, a, p, us, u, stray;
    void'($urandom(32'd1234));
    for (int i = 0; i < 28; i++) shadow[i] = reset_word(i);
    repeat (3) @(negedge clk);
    rst = 0;

    // R1: reset values
    for (int i = 0; i < 28; i++) begin
      bus_read(12'(i * 4), d, e);
      check(d == reset_word(i) && !e, "R1 reset word", d, reset_word(i));
    end

    // R6 R7 R8: reset word gives 1/4, 1/8, 1/16
    main_pulses(64, c);
    check(c == 16, "R6 reset cpu ratio", c, 16);
    begin
      run_chain(256, 1'b0, sel, m, c, a, p, us, u, stray);
      check(m == sel, "R4 main follows pll", m, sel);
      check(a == c / 2 && p == a / 2, "R7 R8 reset ahb/ipg", {a, p}, {c / 2, c / 4});
    end

    // R2: random register traffic
    for (int t = 0; t < 40; t++) begin
      int i;
      logic [31:0] v;
      i = int'($urandom % 28);
      v = $urandom;
      bus_write(12'(i * 4), v, e);
      shadow[i] = v;
      check(!e, "R2 write no error", e, 0);
      i = int'($urandom % 28);
      bus_read(12'(i * 4), d, e);
      check(d == shadow[i] && !e, "R2 readback", d, shadow[i]);
    end

    // R3: bad accesses
    bus_read(12'h070, d, e);
    check(e && d == 0, "R3 read 0x70", {e, d}, {1'b1, 32'h0});
    bus_read(12'hffc, d, e);
    check(e && d == 0, "R3 read 0xffc", {e, d}, {1'b1, 32'h0});
    bus_read(12'h005, d, e);
    check(e && d == 0, "R3 read misaligned", {e, d}, {1'b1, 32'h0});
    bus_write(12'h070, 32'hdeadbeef, e);
    check(e, "R3 write 0x70 err", e, 1);
    bus_write(12'h00e, 32'h12345678, e);
    check(e, "R3 write misaligned err", e, 1);
    for (int i = 0; i < 28; i++) begin
      bus_read(12'(i * 4), d, e);
      check(d == shadow[i], "R3 dropped write", d, shadow[i]);
    end

    // R5 directed: three-quarter step, no division
    bus_write(12'h008, 32'h0000_4000, e);
    main_pulses(8, c);
    check(c == 6, "R5 swallow one of four", c, 6);

    // R10: reload on control write
    bus_write(12'h008, 32'hc000_0000, e);
    main_pulses(2, c);
    bus_write(12'h008, 32'hc000_0000, e);
    main_pulses(3, c);
    check(c == 0, "R10 no early pulse after reload", c, 0);
    main_pulses(1, c);
    check(c == 1, "R10 pulse after full count", c, 1);

    // R4 R5 R6 R7 R8 R9 R11: random control words
    for (int t = 0; t < 24; t++) begin
      bit byp, tq, ud;
      int d1, d2, n, q, ec, ea;
      logic [31:0] w;
      d1 = (t < 4) ? 3 * (t % 2) : int'($urandom % 4);
      d2 = (t < 4) ? 3 * (t / 2) : int'($urandom % 4);
      byp = 1'($urandom % 2); tq = 1'($urandom % 2); ud = 1'($urandom % 2);
      w = (32'(d1) << 30) | (32'(d2) << 28) | (32'(ud) << 23) | (32'(byp) << 22) | (32'(tq) << 14);
      bus_write(12'h008, w, e);
      n = 40 + int'($urandom % 200);
      run_chain(n, byp, sel, m, c, a, p, us, u, stray);
      q  = after_swallow(sel, tq);
      ec = q / (d1 + 1);
      ea = ec / (d2 + 1);
      check(m == sel, "R4 source select", m, sel);
      check(c == ec, "R5 R6 cpu count", c, ec);
      check(a == ea, "R7 ahb count", a, ea);
      check(p == ea / 2, "R8 ipg count", p, ea / 2);
      check(u == (ud ? 0 : us), "R9 usb gating", u, ud ? 0 : us);
      check(stray == 0, "R11 stray pulse", stray, 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule